// File: doc/BRIEF.md
# Host Port Acknowledge Bridge

This block lets an external host processor reach an internal memory bus through a narrow asynchronous bus that is 8 or 16 bits wide. The host drives a chip select and a read or a write strobe. It can also drive an address-cycle strobe. All of these are brought into the core clock domain through a two-flop synchronizer. The bridge gathers one, two or three consecutive host accesses into a single internal word of up to 24 bits. A read fetches the whole word on the first access of the word. A write is issued to memory once the final access of the word has arrived.

A single acknowledge line tells the host when it may end a strobe. In the handshake protocol the line goes active only once the access can finish. In the ready protocol the line sits active and drops to insert wait states. Two pins are sampled while reset is held. They fix the active level of the line and give the initial protocol choice. A small configuration register, reached with the host's register-select line, holds the protocol bit and the word-assembly settings. Software can change the protocol bit later.

The internal side uses a request/done handshake, and the latency of a memory access can vary.

Top module: `hpa_bridge`

## Requirements
- R1: While reset is held, the configuration register loads from the strap pins. Bit 6 (protocol, 1 = ready) is 1 when strap_pol equals strap_ack and 0 when they differ. Bit 7 loads 0. Bit 5 loads strap_pol. Bits 4:2 load 0 and bits 1:0 load 01.
- R2: A host access with host_cfg high reaches the configuration register, and no internal access is made. A write updates bit 7, bit 6, bit 2 (bus width, 1 = 16 bit) and bits 1:0 (accesses per word) from host_din[7:0]. Bit 5 is read-only, and bits 4:3 always read 0. A read returns the register on host_dout[7:0] with zeros above.
- R3: The active level of host_ack equals configuration bit 5, where 1 means active high.
- R4: In handshake mode (bit 6 = 0), host_ack is inactive while no access is present. It goes active when the access can complete, and it returns to inactive after the host removes the strobe.
- R5: In ready mode (bit 6 = 1), host_ack is active while idle. It is inactive while a pending access waits for internal memory, and it is active again once the access can complete.
- R6: Writes are assembled least-significant first. With an 8-bit bus, access k fills word bits [8k+7:8k]. With a 16-bit bus, access 0 fills bits [15:0] and access 1 fills bits [23:16] from host_din[7:0]. Exactly one internal write is made, at the last access of the word, and word bits that no access filled are 0. Earlier accesses are acknowledged without an internal access.
- R7: The first read access of a word makes exactly one internal read. That access and every later access of the same word return slices of the fetched word, using the same layout as R6. The later accesses make no internal access.
- R8: The access that starts a read and the access that completes a write are acknowledged only after mem_done. mem_req, mem_we and mem_wdata stay unchanged until mem_done.
- R9: An address cycle (chip select and address strobe low, with no read or write strobe) is acknowledged and makes no internal access.
- R10: A change of direction between reads and writes restarts assembly at access 0. An accesses-per-word value of 0 behaves as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous reset, active low; the strap pins are sampled while it is low |
| strap_pol | input | 1 | Strap that sets the acknowledge active level |
| strap_ack | input | 1 | Strap level on the acknowledge pin; compared with strap_pol to pick the protocol |
| host_cs_n | input | 1 | Host chip select, active low, asynchronous |
| host_rd_n | input | 1 | Host read strobe, active low, asynchronous |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_as_n | input | 1 | Host address-cycle strobe, active low, asynchronous |
| host_cfg | input | 1 | Selects the configuration register instead of memory |
| host_din | input | 16 | Host write data |
| host_dout | output | 16 | Host read data, held while acknowledged |
| host_ack | output | 1 | Acknowledge or ready line toward the host |
| mem_req | output | 1 | Internal access request, held until done |
| mem_we | output | 1 | Internal access is a write |
| mem_wdata | output | 24 | Assembled internal write word |
| mem_rdata | input | 24 | Internal read word, valid with mem_done |
| mem_done | input | 1 | Internal access finished |

## Verification
The bench resets the block with all four strap combinations. A design that compared the straps the wrong way round would start in the wrong protocol, and one that took polarity from the wrong pin would idle the acknowledge line at the wrong level. It counts internal accesses across multi-byte words. An off-by-one in the access counter would write too early or fetch twice, and a lane error would put bytes in the wrong order, with the highest lane of a 16-bit word being the likely place for it. It also counts ready-mode wait cycles, switches direction in the middle of a word and uses an accesses-per-word setting of zero. A design that acknowledged before the memory finished would show no wait states. A design that did not restart on a direction change would skip the fetch or merge stale bytes into the next word.

// File: rtl/hpa_pkg.sv
package hpa_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MEM  = 2'd1,
        ST_DONE = 2'd2
    } st_e;

    typedef struct packed {
        logic       spare;
        logic       ready;
        logic       pol;
        logic [1:0] rsv;
        logic       wide;
        logic [1:0] bpw;
    } cfg_t;

endpackage

// File: rtl/hpa_sync.sv
module hpa_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stg_q[i] <= '1;
            end else if (i == 0) begin
                stg_q[i] <= d;
            end else begin
                stg_q[i] <= stg_q[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hpa_lane.sv
module hpa_lane #(
    parameter int DATA_W = 16,
    parameter int WORD_W = 24
) (
    input  logic [WORD_W-1:0] base,
    input  logic [DATA_W-1:0] din,
    input  logic [WORD_W-1:0] src,
    input  logic [1:0]        k,
    input  logic              wide,
    output logic [WORD_W-1:0] ins_word,
    output logic [DATA_W-1:0] rd_slice
);
    localparam int EW = WORD_W + 2 * DATA_W;

    logic [EW-1:0] mask_e;
    logic [EW-1:0] ext;
    logic [7:0]    sh;

    always_comb begin
        mask_e   = wide ? EW'({DATA_W{1'b1}}) : EW'({(DATA_W/2){1'b1}});
        sh       = 8'(k) * (wide ? 8'(DATA_W) : 8'(DATA_W/2));
        ext      = (EW'(base) & ~(mask_e << sh)) | ((EW'(din) & mask_e) << sh);
        ins_word = WORD_W'(ext);
        rd_slice = DATA_W'((EW'(src) >> sh) & mask_e);
    end
endmodule

// File: rtl/hpa_ackgen.sv
module hpa_ackgen (
    input  logic pend,
    input  logic done,
    input  logic ready_mode,
    input  logic pol,
    output logic host_ack
);
    logic act;

    always_comb begin
        if (ready_mode) begin
            act = !(pend && !done);
        end else begin
            act = pend && done;
        end
        host_ack = ~(act ^ pol);
    end
endmodule

// File: rtl/hpa_bridge.sv
module hpa_bridge
    import hpa_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int WORD_W      = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strap_pol,
    input  logic              strap_ack,
    input  logic              host_cs_n,
    input  logic              host_rd_n,
    input  logic              host_wr_n,
    input  logic              host_as_n,
    input  logic              host_cfg,
    input  logic [DATA_W-1:0] host_din,
    output logic [DATA_W-1:0] host_dout,
    output logic              host_ack,
    output logic              mem_req,
    output logic              mem_we,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_done
);
    localparam int HALF_W = DATA_W / 2;

    typedef struct packed {
        st_e               st;
        cfg_t              cfg;
        logic [1:0]        cnt;
        logic              dir;
        logic              we;
        logic [WORD_W-1:0] wbuf;
        logic [WORD_W-1:0] rbuf;
        logic [DATA_W-1:0] dout;
    } regs_t;

    regs_t r_q, r_d;

    logic [3:0] strb_s;
    logic cs_s, rd_s, wr_s, as_s;
    logic pend, is_wr;
    logic [1:0] bpw_eff, k;
    logic last;
    logic [WORD_W-1:0] ins_word, lane_base;
    logic [DATA_W-1:0] rd_slice, first_slice;

    hpa_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({host_cs_n, host_rd_n, host_wr_n, host_as_n}),
        .q     (strb_s)
    );

    assign {cs_s, rd_s, wr_s, as_s} = ~strb_s;
    assign pend  = cs_s && (rd_s || wr_s || as_s);
    assign is_wr = wr_s;

    assign bpw_eff   = (r_q.cfg.bpw == 2'd0) ? 2'd1 : r_q.cfg.bpw;
    assign k         = (r_q.dir == is_wr) ? r_q.cnt : 2'd0;
    assign last      = (k == bpw_eff - 2'd1);
    assign lane_base = (k == 2'd0) ? '0 : r_q.wbuf;

    hpa_lane #(.DATA_W(DATA_W), .WORD_W(WORD_W)) u_lane (
        .base     (lane_base),
        .din      (host_din),
        .src      (r_q.rbuf),
        .k        (k),
        .wide     (r_q.cfg.wide),
        .ins_word (ins_word),
        .rd_slice (rd_slice)
    );

    assign first_slice = r_q.cfg.wide ? DATA_W'(mem_rdata[DATA_W-1:0])
                                      : DATA_W'(mem_rdata[HALF_W-1:0]);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (pend) begin
                    if (as_s && !rd_s && !wr_s) begin
                        r_d.st = ST_DONE;
                    end else if (host_cfg) begin
                        if (is_wr) begin
                            r_d.cfg.spare = host_din[7];
                            r_d.cfg.ready = host_din[6];
                            r_d.cfg.wide  = host_din[2];
                            r_d.cfg.bpw   = host_din[1:0];
                        end
                        r_d.dout = DATA_W'(r_q.cfg);
                        r_d.st   = ST_DONE;
                    end else if (is_wr) begin
                        r_d.dir  = 1'b1;
                        r_d.wbuf = ins_word;
                        if (last) begin
                            r_d.we = 1'b1;
                            r_d.st = ST_MEM;
                        end else begin
                            r_d.cnt = k + 2'd1;
                            r_d.st  = ST_DONE;
                        end
                    end else begin
                        r_d.dir = 1'b0;
                        if (k == 2'd0) begin
                            r_d.we = 1'b0;
                            r_d.st = ST_MEM;
                        end else begin
                            r_d.dout = rd_slice;
                            r_d.cnt  = last ? 2'd0 : k + 2'd1;
                            r_d.st   = ST_DONE;
                        end
                    end
                end
            end
            ST_MEM: begin
                if (mem_done) begin
                    r_d.st = ST_DONE;
                    if (r_q.we) begin
                        r_d.cnt = 2'd0;
                    end else begin
                        r_d.rbuf = mem_rdata;
                        r_d.dout = first_slice;
                        r_d.cnt  = (bpw_eff == 2'd1) ? 2'd0 : 2'd1;
                    end
                end
            end
            default: begin
                if (!pend) r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q           <= '0;
            r_q.st        <= ST_IDLE;
            r_q.cfg.ready <= (strap_pol == strap_ack);
            r_q.cfg.pol   <= strap_pol;
            r_q.cfg.bpw   <= 2'd1;
        end else begin
            r_q <= r_d;
        end
    end

    hpa_ackgen u_ack (
        .pend       (pend),
        .done       (r_q.st == ST_DONE),
        .ready_mode (r_q.cfg.ready),
        .pol        (r_q.cfg.pol),
        .host_ack   (host_ack)
    );

    assign host_dout = r_q.dout;
    assign mem_req   = (r_q.st == ST_MEM);
    assign mem_we    = r_q.we;
    assign mem_wdata = r_q.wbuf;

    // R8
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_done |=> mem_req);

    // R8
    req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_done |=> $stable(mem_we) && $stable(mem_wdata));

    // R2
    pol_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(r_q.cfg.pol));

    // R4
    ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.cfg.ready && !pend |-> host_ack != r_q.cfg.pol);

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.cnt != 2'd3);
endmodule

// File: tb/sim_hpa_bridge.sv
module sim_hpa_bridge;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_pol = 1'b0, strap_ack = 1'b0;
    logic        host_cs_n = 1'b1, host_rd_n = 1'b1, host_wr_n = 1'b1, host_as_n = 1'b1;
    logic        host_cfg = 1'b0;
    logic [15:0] host_din = '0;
    logic [15:0] host_dout;
    logic        host_ack;
    logic        mem_req, mem_we;
    logic [23:0] mem_wdata;
    logic [23:0] mem_rdata = '0;
    logic        mem_done = 1'b0;

    int total = 0, bad = 0;
    int n_rd = 0, n_wr = 0;
    logic cur_pol = 1'b0;
    logic [23:0] exp_wq [$];
    bit finished = 1'b0;

    always #10 clk = ~clk;

    hpa_bridge u0 (
        .clk(clk), .rst_n(rst_n), .strap_pol(strap_pol), .strap_ack(strap_ack),
        .host_cs_n(host_cs_n), .host_rd_n(host_rd_n), .host_wr_n(host_wr_n),
        .host_as_n(host_as_n), .host_cfg(host_cfg), .host_din(host_din),
        .host_dout(host_dout), .host_ack(host_ack), .mem_req(mem_req),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .mem_done(mem_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // memory model and write monitor (scoreboard consumer)
    always begin
        @(negedge clk);
        if (rst_n && mem_req && !mem_done) begin
            repeat (LAT - 1) @(negedge clk);
            if (mem_we) begin
                n_wr++;
                total++;
                if (exp_wq.size() == 0) begin
                    bad++;
                    $display("FAIL R6: actual=%0h expected=none", mem_wdata);
                end else begin
                    logic [23:0] e;
                    e = exp_wq.pop_front();
                    if (mem_wdata !== e) begin
                        bad++;
                        $display("FAIL R6: actual=%0h expected=%0h", mem_wdata, e);
                    end
                end
            end else begin
                n_rd++;
            end
            mem_done = 1'b1;
            @(negedge clk);
            mem_done = 1'b0;
        end
    end

    task automatic do_reset(input logic p, input logic a);
        @(negedge clk);
        rst_n = 1'b0; strap_pol = p; strap_ack = a; cur_pol = p;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    // kind: 0 memory, 1 config, 2 address cycle
    task automatic host_op(input int kind, input logic wr, input logic [15:0] d,
                           output logic [15:0] q, output int waits);
        waits = 0;
        @(negedge clk);
        host_cfg = (kind == 1); host_din = d; host_cs_n = 1'b0;
        if (kind == 2) host_as_n = 1'b0;
        else if (wr) host_wr_n = 1'b0;
        else host_rd_n = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (host_ack !== cur_pol) waits++;
        end
        for (int i = 0; i < 200 && host_ack !== cur_pol; i++) begin
            @(negedge clk);
            if (host_ack !== cur_pol) waits++;
        end
        q = host_dout;
        host_cs_n = 1'b1; host_rd_n = 1'b1; host_wr_n = 1'b1; host_as_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wr_mem(input logic [15:0] d, output int waits);
        logic [15:0] q;
        host_op(0, 1'b1, d, q, waits);
    endtask

    task automatic rd_mem(output logic [15:0] q, output int waits);
        host_op(0, 1'b0, 16'h0, q, waits);
    endtask

    task automatic cfg_wr(input logic [7:0] v);
        logic [15:0] q; int w;
        host_op(1, 1'b1, {8'h00, v}, q, w);
    endtask

    task automatic cfg_rd(output logic [15:0] q);
        int w;
        host_op(1, 1'b0, 16'h0, q, w);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [15:0] q;
        int w, r0, w0;

        // R1 / R3 / R5: straps 00 -> ready, active low
        do_reset(1'b0, 1'b0);
        chk("R5 idle ack ready low", {31'b0, host_ack}, 32'h0);
        cfg_rd(q);
        chk("R1 cfg straps 00", q, 16'h0041);
        // straps 01 -> handshake
        do_reset(1'b0, 1'b1);
        chk("R4 idle ack hs low", {31'b0, host_ack}, 32'h1);
        cfg_rd(q);
        chk("R1 cfg straps 01", q, 16'h0001);
        // straps 10
        do_reset(1'b1, 1'b0);
        chk("R3 idle ack hs high", {31'b0, host_ack}, 32'h0);
        cfg_rd(q);
        chk("R1 cfg straps 10", q, 16'h0021);
        // straps 11
        do_reset(1'b1, 1'b1);
        chk("R3 idle ack ready high", {31'b0, host_ack}, 32'h1);
        cfg_rd(q);
        chk("R1 cfg straps 11", q, 16'h0061);

        // R2: writable fields, read-only pol, zero reserved
        cfg_wr(8'hDB);
        cfg_rd(q);
        chk("R2 cfg readback", q, 16'h00E3);
        chk("R2 no mem access", n_rd + n_wr, 0);

        // R6 / R8 / R5: three-byte write in ready mode
        exp_wq.push_back(24'h332211);
        wr_mem(16'h0011, w);
        chk("R5 immediate ack wait", w <= 2, 1);
        wr_mem(16'h0022, w);
        chk("R6 no early write", n_wr, 0);
        wr_mem(16'h0033, w);
        chk("R8 final write waits", w >= LAT - 1, 1);
        chk("R6 one write", n_wr, 1);

        // R7: three-byte read
        mem_rdata = 24'hA5B6C7;
        rd_mem(q, w);
        chk("R7 byte0", q, 16'h00C7);
        chk("R5 read wait states", w >= LAT - 1, 1);
        mem_rdata = 24'h000000;
        rd_mem(q, w);
        chk("R7 byte1", q, 16'h00B6);
        rd_mem(q, w);
        chk("R7 byte2", q, 16'h00A5);
        chk("R7 one read", n_rd, 1);

        // R4 / R6: handshake mode, 16-bit, two accesses
        cfg_wr(8'h06);
        cfg_rd(q);
        chk("R2 cfg readback 2", q, 16'h0026);
        chk("R4 idle ack inactive", {31'b0, host_ack}, 32'h0);
        exp_wq.push_back(24'h34BEEF);
        wr_mem(16'hBEEF, w);
        chk("R4 ack released", {31'b0, host_ack}, 32'h0);
        wr_mem(16'h1234, w);
        chk("R6 wide write count", n_wr, 2);

        // R7: 16-bit read
        mem_rdata = 24'h987654;
        rd_mem(q, w);
        chk("R7 wide lo", q, 16'h7654);
        rd_mem(q, w);
        chk("R7 wide hi", q, 16'h0098);
        chk("R7 wide one read", n_rd, 2);

        // R9: address cycle
        r0 = n_rd; w0 = n_wr;
        host_op(2, 1'b0, 16'h0, q, w);
        chk("R9 addr cycle no access", (n_rd - r0) + (n_wr - w0), 0);
        chk("R9 ack released", {31'b0, host_ack}, 32'h0);

        // R10: direction change restarts word
        cfg_wr(8'h02);
        cfg_rd(q);
        chk("R2 cfg readback 3", q, 16'h0022);
        wr_mem(16'h0055, w);
        mem_rdata = 24'h0000E1;
        rd_mem(q, w);
        chk("R10 read restarts", n_rd, 3);
        chk("R10 read byte0", q, 16'h00E1);
        exp_wq.push_back(24'h007766);
        wr_mem(16'h0066, w);
        chk("R10 write restarts", n_wr, 2);
        wr_mem(16'h0077, w);
        chk("R10 write done", n_wr, 3);

        // R10: accesses-per-word 0 acts as 1
        cfg_wr(8'h00);
        cfg_rd(q);
        chk("R2 cfg readback 4", q, 16'h0020);
        exp_wq.push_back(24'h000099);
        wr_mem(16'h0099, w);
        chk("R10 bpw0 single", n_wr, 4);
        chk("R6 queue drained", exp_wq.size(), 0);

        finish_run();
    end
endmodule